// File: doc/BRIEF.md
# XOR Flit Receive Decoder

This block sits at one input channel of a network-on-chip router and turns a stream of link values back into plain flits. Upstream, flits that collided in the switch were sent XOR-combined, not held back. Each link value comes with a coded flag. A coded value is kept in a held register. The next value that arrives is XORed with it, which gives back one original flit. The last value of a collision run comes uncoded. That value completes the previous flit and is also a flit in its own right, so two entries enter the buffer in that cycle.

Recovered flits go into a four-entry buffer in the order the upstream arbiter chose. The router core reads them through a valid/ready dequeue port. The XOR step is one gate level deep at any router radix. The input side has no per-beat handshake. Instead, `in_ready` works as a credit level: it is high only while at least two buffer entries are free. A sender may drive `in_valid` only in cycles where `in_ready` is high. On the output side, a flit leaves in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head flit and `out_valid` stay unchanged.

Top module: `xor_flit_rx`

## Requirements
- R1: While reset is asserted and after it is released, no decoded value is pending, the buffer is empty (`out_valid` = 0) and `in_ready` = 1.
- R2: An uncoded value (`in_coded` = 0) that arrives with nothing pending is queued unchanged as one flit.
- R3: A coded value (`in_coded` = 1) that arrives with nothing pending queues nothing and becomes the pending value. It stays pending through idle cycles.
- R4: A coded value that arrives while a value is pending queues pending XOR new as one flit, and the new value becomes the pending one.
- R5: An uncoded value that arrives while a value is pending queues two flits in the same cycle: first pending XOR new, then the new value itself. After that nothing is pending. The run A^B^C (coded), B^C (coded), C (uncoded) therefore produces A, B, C in that order.
- R6: Flits leave in the order they were queued. While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_data` hold steady.
- R7: The buffer holds DEPTH = 4 flits. `in_ready` = 1 exactly when at least two entries are free, and a sender drives `in_valid` only while `in_ready` = 1.
- R8: A push and a pop in the same cycle are both counted. With the reader always ready, back-to-back three-value collision runs never lower `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A link value is present this cycle |
| in_coded | input | 1 | The link value is an XOR combination |
| in_data | input | 64 | Link value |
| in_ready | output | 1 | Credit level: at least two free entries |
| out_valid | output | 1 | Head flit available |
| out_ready | input | 1 | Core accepts the head flit |
| out_data | output | 64 | Head flit |

## Verification
The assertions check, on every cycle, the rules that depend only on the current state and one step of history. These are: the pending flag follows the coded flag, the head flit stays stable under back-pressure, the buffer never overflows, and the sender respects the credit level. Only the bench scenarios can show that the decoded values are correct. This covers the XOR results, two-flit enqueues in the right order across collision runs, a coded value held through idle gaps, the exact fill at which credit drops, and streaming with simultaneous push and pop.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  // number of flits written into the buffer in one cycle
  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_e;
endpackage

// File: rtl/xfr_decode.sv
module xfr_decode
  import xfr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_coded,
  input  logic [DATA_W-1:0] in_data,
  output push_e             push,
  output logic [DATA_W-1:0] word0,
  output logic [DATA_W-1:0] word1,
  output logic              pend
);
  logic              pend_q;
  logic [DATA_W-1:0] held_q;

  assign pend  = pend_q;
  assign word1 = in_data;

  always_comb begin
    push  = PUSH_NONE;
    word0 = in_data;
    if (in_valid) begin
      if (pend_q) begin
        word0 = held_q ^ in_data;
        push  = in_coded ? PUSH_ONE : PUSH_TWO;
      end else if (!in_coded) begin
        push = PUSH_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      held_q <= '0;
    end else if (in_valid) begin
      pend_q <= in_coded;
      if (in_coded) held_q <= in_data;
    end
  end
endmodule

// File: rtl/xfr_fifo.sv
module xfr_fifo
  import xfr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  push_e                      push,
  input  logic [DATA_W-1:0]          word0,
  input  logic [DATA_W-1:0]          word1,
  input  logic                       pop_ready,
  output logic                       head_valid,
  output logic [DATA_W-1:0]          head_data,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       space_two
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] CREDIT_MAX = CNT_W'(DEPTH - 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill_q, n_push;
  logic [1:0]        push_raw;
  logic              pop;

  assign push_raw   = push;
  assign n_push     = CNT_W'(push_raw);
  assign head_valid = (fill_q != '0);
  assign head_data  = mem[rd_ptr];
  assign pop        = head_valid && pop_ready;
  assign fill       = fill_q;
  assign space_two  = (fill_q <= CREDIT_MAX);

  always_ff @(posedge clk) begin
    if (push != PUSH_NONE) mem[wr_ptr] <= word0;
    if (push == PUSH_TWO)  mem[PTR_W'(wr_ptr + 1'b1)] <= word1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      wr_ptr <= PTR_W'(wr_ptr + n_push[PTR_W-1:0]);
      if (pop) rd_ptr <= PTR_W'(rd_ptr + 1'b1);
      fill_q <= fill_q + n_push - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/xor_flit_rx.sv
module xor_flit_rx
  import xfr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_coded,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = $clog2(DEPTH+1);

  push_e                push;
  logic [DATA_W-1:0]    word0, word1;
  logic                 pend;
  logic [CNT_W-1:0]     fill;

  xfr_decode #(.DATA_W(DATA_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coded(in_coded),
    .in_data(in_data), .push(push), .word0(word0), .word1(word1), .pend(pend)
  );

  xfr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) buf_i (
    .clk(clk), .rst_n(rst_n), .push(push), .word0(word0), .word1(word1),
    .pop_ready(out_ready), .head_valid(out_valid), .head_data(out_data),
    .fill(fill), .space_two(in_ready)
  );
endmodule

// File: rtl/xfr_checker.sv
module xfr_checker #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_coded,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DATA_W-1:0]          out_data,
  input logic                       pend,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  logic rst_seen_q = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) rst_seen_q <= 1'b1;
    // R1
    if (!rst_n && rst_seen_q) reset_state_chk: assert (!pend && !out_valid && in_ready);
  end

  // R7
  sender_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));
  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R3
  coded_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_coded |=> pend);
  // R3
  idle_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pend));
  // R5
  plain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_coded |=> !pend);
endmodule

bind xor_flit_rx xfr_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coded(in_coded),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .pend(pend), .fill(fill)
);

// File: tb/xor_flit_rx_tb_top.sv
module xor_flit_rx_tb_top;
  localparam int DW = 64;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid = 1'b0, in_coded = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0, cycles = 0;
  int rdy_mode = 1;            // 0 never ready, 1 always ready, 2 random
  bit track = 1'b0, saw_stall = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;       // 50 MHz

  xor_flit_rx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coded(in_coded),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_flit(logic [DW-1:0] d, string tag);
    exp_q.push_back(d);
    tag_q.push_back(tag);
  endtask

  // called at a negedge, returns at a negedge
  task automatic send(bit coded, logic [DW-1:0] d);
    if (track && !in_ready) saw_stall = 1'b1;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_coded = coded; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // driver: encodes a collision run of n flits and records the plain flits
  task automatic group(int n, logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    if (n == 1) begin
      expect_flit(a, "R2");
      send(1'b0, a);
    end else if (n == 2) begin
      expect_flit(a, "R5"); expect_flit(b, "R5");
      send(1'b1, a ^ b); send(1'b0, b);
    end else begin
      expect_flit(a, "R4"); expect_flit(b, "R5"); expect_flit(c, "R5");
      send(1'b1, a ^ b ^ c); send(1'b1, b ^ c); send(1'b0, c);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // monitor: picks out_ready, then compares the flit taken at the next edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      out_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'($urandom % 2) : 1'b0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected flit", out_data, '0);
        else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, out_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  initial begin
    logic [DW-1:0] x, y, snap;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid", DW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 ready/empty", DW'({in_ready, out_valid}), DW'(2'b10));

    // R2 R4 R5: plain, two- and three-flit collision runs
    rdy_mode = 1;
    group(1, 64'h1111_0000_0000_0001, '0, '0);
    group(1, 64'hDEAD_BEEF_0000_0002, '0, '0);
    group(2, 64'hAAAA_5555_0000_0003, 64'h0F0F_F0F0_0000_0004, '0);
    group(3, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h8000_0000_0000_0001);
    drain();

    // R3: a coded value alone queues nothing and stays pending over idle cycles
    x = 64'hCAFE_0000_1234_5678; y = 64'h0000_BABE_8765_4321;
    send(1'b1, x ^ y);
    repeat (4) @(negedge clk);
    chk(!out_valid, "R3 nothing queued", DW'(out_valid), '0);
    expect_flit(x, "R3"); expect_flit(y, "R3");
    send(1'b0, y);
    drain();

    // R7: credit level with the reader stalled
    rdy_mode = 0;
    @(negedge clk);
    group(1, 64'h1, '0, '0);
    group(1, 64'h2, '0, '0);
    chk(in_ready, "R7 two free", DW'(in_ready), DW'(1));
    group(1, 64'h3, '0, '0);
    chk(!in_ready, "R7 one free", DW'(in_ready), '0);
    // R6: head held under back-pressure
    snap = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == snap, "R6 hold", out_data, snap);
    rdy_mode = 1;
    drain();
    rdy_mode = 0;
    @(negedge clk);
    group(2, 64'h10, 64'h20, '0);
    chk(in_ready, "R7 fill two", DW'(in_ready), DW'(1));
    group(2, 64'h30, 64'h40, '0);
    chk(!in_ready && out_valid, "R7 full", DW'({in_ready, out_valid}), DW'(2'b01));
    rdy_mode = 1;
    drain();

    // R8: streaming runs with simultaneous push and pop never lose credit
    track = 1'b1;
    for (int i = 0; i < 20; i++) group(3, rnd64(), rnd64(), rnd64());
    track = 1'b0;
    chk(!saw_stall, "R8 no stall", DW'(saw_stall), '0);
    drain();

    // R6: ordering under random back-pressure and mixed run lengths
    rdy_mode = 2;
    for (int i = 0; i < 200; i++) group(1 + int'($urandom % 3), rnd64(), rnd64(), rnd64());
    drain();
    chk(exp_q.size() == 0, "R6 all delivered", DW'(exp_q.size()), '0);
    summary();
  end
endmodule